// File: doc/BRIEF.md
# Sector Window Fault Interrupt Monitor

This block checks two disk-channel fault flags against sector timing and sends a fault interrupt to the host controller. The sector strobe `sos_ni` is active low. It falls when a sector begins and rises when the sector ends. The write-unsafe flag counts only inside a qualification window. The window opens a fixed time after the strobe falls, and it closes when the strobe rises. The parity-error flag counts at any time inside the sector, but only while the parity-check enable is high.

During a sector, the faults that count are collected in a per-sector pending vector. When the strobe rises, this vector is ORed into a sticky status word and then cleared, ready for the next sector. If any fault was pending, the active-low interrupt is asserted on that same edge. The interrupt is not raised while the faulty sector is still running. The host releases the interrupt and empties the status word by pulsing `irq_clr_i`.

All inputs are synchronous to `clk_i`. The window delay is a number of clock cycles, computed from the clock frequency parameter and the delay in nanoseconds. The result is rounded up and is never less than one cycle.

Top module: `sector_fault_monitor`

## Requirements
- R1: After reset, `irq_no` is 1 (inactive) and `fault_status_o` is 0.
- R2: Call the clock edge that first samples `sos_ni` low edge 0. `unsafe_i` sampled high at edges 1 to D-1 is ignored. D is the window delay in cycles (125 at the default 125 MHz clock and 1000 ns delay).
- R3: `unsafe_i` sampled high at any edge from edge D onward counts as an unsafe fault, as long as `sos_ni` is still sampled low at that edge.
- R4: `unsafe_i` sampled while `sos_ni` is high never counts, including on the edge where the strobe rises.
- R5: `parity_err_i` counts as a parity fault only on an edge where `sos_ni` is low and `parity_en_i` is high.
- R6: `irq_no` goes low only on the edge that samples `sos_ni` rising at the end of a sector in which a fault counted. It stays high throughout that sector.
- R7: `fault_status_o` bit 0 records unsafe faults and bit 1 records parity faults. On each sector end, the sector's pending faults are ORed into the status word, which keeps its earlier bits.
- R8: Once asserted, `irq_no` and `fault_status_o` hold until an edge samples `irq_clr_i` high. That edge sets `irq_no` to 1 and `fault_status_o` to 0.
- R9: If `irq_clr_i` is sampled on the same edge as the end of a faulty sector, `irq_no` stays low. The status word then holds only that sector's faults.
- R10: In a sector whose low phase lasts D edges or fewer, the window never opens, so unsafe faults cannot count in it.
- R11: Pending faults do not carry into the next sector. A clean sector after a clear raises no interrupt and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sos_ni | input | 1 | Sector strobe, low for the duration of a sector |
| unsafe_i | input | 1 | Write-unsafe flag from the preamplifier |
| parity_err_i | input | 1 | Parity error flag |
| parity_en_i | input | 1 | Parity check enable |
| irq_clr_i | input | 1 | Host interrupt clear / acknowledge pulse |
| fault_status_o | output | 2 | Sticky fault status: bit 0 unsafe, bit 1 parity |
| irq_no | output | 1 | Fault interrupt request, active low |

## Verification
The bench puts an unsafe pulse on the last edge before the window (edge D-1), then on the first edge inside it (edge D), then on the last low edge of a sector. An off-by-one window delay would either miss a real fault or flag a fault too early. One sector lasts exactly D edges with unsafe held high throughout, to catch a window that opens as the strobe rises. A clear that coincides with a faulty sector end must leave the interrupt asserted. A design that gave the clear priority would drop that interrupt. Back-to-back sectors, one with and one without a clear between them, show whether the status word is sticky and whether pending faults leak from one sector into the next.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int FLT_UNSAFE = 0;
  localparam int FLT_PARITY = 1;
  localparam int NUM_FLT    = 2;

  typedef logic [NUM_FLT-1:0] flt_vec_t;

  // cycles covering win_ns at clk_hz, rounded up, at least one
  function automatic int win_cycles(input longint clk_hz, input longint win_ns);
    longint c;
    c = (clk_hz * win_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/sfm_sector_timer.sv
module sfm_sector_timer #(
  parameter longint CLK_HZ = 125_000_000,
  parameter longint WIN_NS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sos_ni,
  output logic sec_end_o,
  output logic in_sec_o,
  output logic win_o
);
  import sfm_pkg::*;

  localparam int DELAY = win_cycles(CLK_HZ, WIN_NS);
  localparam int CW    = $clog2(DELAY + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DELAY);

  logic          sos_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sos_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      sos_q <= sos_ni;
      if (sos_ni)              cnt_q <= '0;
      else if (cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_sec_o  = ~sos_ni;
  assign sec_end_o = sos_ni & ~sos_q;
  assign win_o     = ~sos_ni & (cnt_q == CNT_MAX);
endmodule

// File: rtl/sfm_fault_accum.sv
module sfm_fault_accum
  import sfm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sec_end_i,
  input  logic     in_sec_i,
  input  logic     win_i,
  input  logic     unsafe_i,
  input  logic     parity_err_i,
  input  logic     parity_en_i,
  output flt_vec_t pend_o
);
  flt_vec_t pend_q;
  flt_vec_t hit;

  always_comb begin
    hit             = '0;
    hit[FLT_UNSAFE] = win_i & unsafe_i;
    hit[FLT_PARITY] = parity_en_i & parity_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= '0;
    else if (sec_end_i) pend_q <= '0;
    else if (in_sec_i)  pend_q <= pend_q | hit;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sfm_irq_ctrl.sv
module sfm_irq_ctrl
  import sfm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sec_end_i,
  input  flt_vec_t pend_i,
  input  logic     clr_i,
  output flt_vec_t status_o,
  output logic     irq_no
);
  flt_vec_t status_q;
  logic     irq_q;
  flt_vec_t status_base;
  logic     irq_base;

  // a clear wipes old state first; a faulty sector end then sets it again
  assign status_base = clr_i ? '0 : status_q;
  assign irq_base    = clr_i ? 1'b0 : irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else if (sec_end_i) begin
      status_q <= status_base | pend_i;
      irq_q    <= irq_base | (|pend_i);
    end else if (clr_i) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_no   = ~irq_q;
endmodule

// File: rtl/sector_fault_monitor.sv
module sector_fault_monitor
  import sfm_pkg::*;
#(
  parameter longint CLK_HZ = 125_000_000,
  parameter longint WIN_NS = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sos_ni,
  input  logic                unsafe_i,
  input  logic                parity_err_i,
  input  logic                parity_en_i,
  input  logic                irq_clr_i,
  output logic [NUM_FLT-1:0]  fault_status_o,
  output logic                irq_no
);
  logic     sec_end_w;
  logic     in_sec_w;
  logic     win_w;
  flt_vec_t pend_w;
  flt_vec_t status_w;

  sfm_sector_timer #(.CLK_HZ(CLK_HZ), .WIN_NS(WIN_NS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sos_ni    (sos_ni),
    .sec_end_o (sec_end_w),
    .in_sec_o  (in_sec_w),
    .win_o     (win_w)
  );

  sfm_fault_accum u_accum (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sec_end_i    (sec_end_w),
    .in_sec_i     (in_sec_w),
    .win_i        (win_w),
    .unsafe_i     (unsafe_i),
    .parity_err_i (parity_err_i),
    .parity_en_i  (parity_en_i),
    .pend_o       (pend_w)
  );

  sfm_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_end_i (sec_end_w),
    .pend_i    (pend_w),
    .clr_i     (irq_clr_i),
    .status_o  (status_w),
    .irq_no    (irq_no)
  );

  assign fault_status_o = status_w;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker
  import sfm_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     sos_ni,
  input logic     unsafe_i,
  input logic     parity_err_i,
  input logic     parity_en_i,
  input logic     irq_clr_i,
  input flt_vec_t status_i,
  input logic     irq_ni,
  input logic     win_i,
  input flt_vec_t pend_i
);
  // R6
  irq_at_sector_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_ni) |-> ($past(sos_ni) && !$past(sos_ni, 2)));

  // R8
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ni) |-> $past(irq_clr_i));

  // R8
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_i) |-> ($past(irq_clr_i) || ($past(sos_ni) && !$past(sos_ni, 2))));

  // R9
  fault_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sos_ni && !$past(sos_ni) && (pend_i != '0)) |=> !irq_ni);

  // R3
  unsafe_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && unsafe_i) |=> pend_i[FLT_UNSAFE]);

  // R2
  unsafe_needs_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i[FLT_UNSAFE]) |-> $past(win_i && unsafe_i));

  // R5
  parity_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i[FLT_PARITY]) |-> $past(parity_en_i && parity_err_i && !sos_ni));
endmodule

bind sector_fault_monitor sfm_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sos_ni       (sos_ni),
  .unsafe_i     (unsafe_i),
  .parity_err_i (parity_err_i),
  .parity_en_i  (parity_en_i),
  .irq_clr_i    (irq_clr_i),
  .status_i     (status_w),
  .irq_ni       (irq_no),
  .win_i        (win_w),
  .pend_i       (pend_w)
);

// File: tb/sector_fault_monitor_tb.sv
module sector_fault_monitor_tb;
  localparam int D = 1000 / 8;  // 1 us window at 8 ns period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sos_n = 1'b1;
  logic       unsafe = 1'b0;
  logic       perr = 1'b0;
  logic       pen = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] status;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  int         m_k = -1;
  bit         m_prev = 1'b1;
  bit [1:0]   m_pend = '0;
  bit [1:0]   m_stat = '0;
  bit         m_irq = 1'b0;

  always #4 clk = ~clk;

  sector_fault_monitor u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sos_ni         (sos_n),
    .unsafe_i       (unsafe),
    .parity_err_i   (perr),
    .parity_en_i    (pen),
    .irq_clr_i      (clr),
    .fault_status_o (status),
    .irq_no         (irq_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the requirements, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_k = -1; m_prev = 1'b1; m_pend = '0; m_stat = '0; m_irq = 1'b0;
    end else begin
      if (!sos_n) begin
        m_k = m_prev ? 0 : m_k + 1;
        if (unsafe && m_k >= D) m_pend[0] = 1'b1;
        if (perr && pen)        m_pend[1] = 1'b1;
      end else begin
        m_k = -1;
      end
      if (sos_n && !m_prev) begin
        m_stat = (clr ? 2'b00 : m_stat) | m_pend;
        m_irq  = (clr ? 1'b0 : m_irq) | (|m_pend);
        m_pend = '0;
      end else if (clr) begin
        m_stat = '0;
        m_irq  = 1'b0;
      end
      m_prev = sos_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_n == !m_irq, "MODEL irq", int'(irq_n), int'(!m_irq));
      chk(status == m_stat, "MODEL status", int'(status), int'(m_stat));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic pre_irq;

  // low phase of len edges; unsafe high for edges ua..ub, parity at edge pa
  task automatic run_sector(input int len, input int ua, input int ub, input int pa,
                            input bit en, input bit clr_end);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sos_n = 1'b0; unsafe = (i >= ua && i <= ub); perr = (i == pa); pen = en;
    end
    @(negedge clk);
    pre_irq = irq_n;
    sos_n = 1'b1; unsafe = 1'b0; perr = 1'b0; clr = clr_end;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic idle(input int n, input bit u);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sos_n = 1'b1; unsafe = u; perr = u; pen = u;
    end
    @(negedge clk);
    unsafe = 1'b0; perr = 1'b0; pen = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq", irq_n, 1);
    chk(status == 2'b00, "R1 status", status, 0);

    run_sector(200, D - 1, D - 1, -1, 1'b0, 1'b0);
    chk(irq_n == 1'b1, "R2 early unsafe irq", irq_n, 1);
    chk(status == 2'b00, "R2 early unsafe status", status, 0);

    run_sector(200, D, D, -1, 1'b0, 1'b0);
    chk(pre_irq == 1'b1, "R6 no irq mid-sector", pre_irq, 1);
    chk(irq_n == 1'b0, "R6 irq at end", irq_n, 0);
    chk(status == 2'b01, "R3 first window edge", status, 1);

    idle(20, 1'b0);
    chk(irq_n == 1'b0, "R8 irq held", irq_n, 0);
    chk(status == 2'b01, "R8 status held", status, 1);
    pulse_clr();
    chk(irq_n == 1'b1, "R8 irq cleared", irq_n, 1);
    chk(status == 2'b00, "R8 status cleared", status, 0);

    idle(10, 1'b1);
    run_sector(150, 1, 0, -1, 1'b0, 1'b0);
    chk(irq_n == 1'b1, "R4 unsafe outside sector", irq_n, 1);
    chk(status == 2'b00, "R4 status", status, 0);

    run_sector(200, 199, 199, -1, 1'b0, 1'b0);
    chk(status == 2'b01, "R3 last low edge", status, 1);
    pulse_clr();

    run_sector(D, 0, D - 1, -1, 1'b0, 1'b0);
    chk(irq_n == 1'b1, "R10 short sector irq", irq_n, 1);
    chk(status == 2'b00, "R10 short sector status", status, 0);

    run_sector(100, 1, 0, 50, 1'b0, 1'b0);
    chk(irq_n == 1'b1, "R5 parity disabled", irq_n, 1);
    run_sector(100, 1, 0, 50, 1'b1, 1'b0);
    chk(irq_n == 1'b0, "R5 parity enabled irq", irq_n, 0);
    chk(status == 2'b10, "R7 parity bit", status, 2);

    run_sector(200, D + 5, D + 5, -1, 1'b0, 1'b0);
    chk(status == 2'b11, "R7 sticky OR", status, 3);

    run_sector(100, 1, 0, 10, 1'b1, 1'b1);
    chk(irq_n == 1'b0, "R9 irq kept", irq_n, 0);
    chk(status == 2'b10, "R9 status fresh", status, 2);

    pulse_clr();
    run_sector(200, 1, 0, -1, 1'b1, 1'b0);
    chk(irq_n == 1'b1, "R11 clean sector irq", irq_n, 1);
    chk(status == 2'b00, "R11 clean sector status", status, 0);

    idle(5, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule